// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Generator

This block produces the system reset for a processor from three causes: the supply first becoming good after power is applied, the supply dropping out, and a watchdog that was not restarted in time. A synchronous supply-good flag from an external comparator gates everything. While that flag is low the reset is held. Once it returns, a fixed reset period runs out before the processor is released. The same reset timer also serves watchdog expiry, so every reset episode lasts the same number of clock cycles.

The watchdog is restarted by a chip-select style, active-low command strobe. A 2-bit code selects one of three watchdog periods, and its all-ones value switches the watchdog off. A new code is written with a load strobe but stays pending. It becomes active only when the next command ends, which is the rising edge of the command strobe, or after power is removed and re-applied. All times are parameters counted in clock cycles, so simulation can use short periods. The output is an enable that pulls an external open-drain reset line low.

Top module: `supv_reset_gen`

## Requirements
- R1: After `pwr_on_n` rises with `supply_ok` high, `rst_drv_low` stays 1 for exactly RST_TICKS+1 clock cycles and then goes to 0.
- R2: One cycle after `supply_ok` is sampled low, `rst_drv_low` is 1. It stays 1 for as long as `supply_ok` stays low.
- R3: After `supply_ok` returns high, `rst_drv_low` stays 1 for exactly RST_TICKS+1 cycles. Reset is never released unless `supply_ok` was high in the previous cycle.
- R4: With the watchdog enabled and no restart, reset is released for exactly the selected period and then asserts. Code 00 gives WDT_LONG cycles, 01 gives WDT_MID and 10 gives WDT_SHORT.
- R5: Code 11 disables the watchdog: no watchdog reset occurs, however long `kick_n` stays idle.
- R6: The active code and the pending code are both 11 after `pwr_on_n` is low, including after a later power cycle.
- R7: A watchdog expiry holds `rst_drv_low` at 1 for exactly RST_TICKS cycles.
- R8: `kick_n` passes through a two-flop synchronizer. Each synchronized falling edge restarts the watchdog count, so kicks spaced closer than the period prevent any reset.
- R9: `sel_load` captures `tmo_sel` as the pending code. That code takes effect only at the synchronized rising edge of `kick_n`, and until then the active period is unchanged. The edge that applies a code also restarts the count.
- R10: The watchdog count is held at zero while reset is asserted, so the first period after any reset is a full period.
- R11: `rst_drv_low` is 1 to pull the reset line low and 0 to leave it to the external pull-up. The block never drives the line high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_on_n | input | 1 | Asynchronous power-applied indication; low clears all state |
| supply_ok | input | 1 | Synchronous supply-good flag from the external comparator |
| kick_n | input | 1 | Active-low command strobe; a falling edge restarts the watchdog, a rising edge ends a command |
| tmo_sel | input | 2 | Watchdog period code (00 long, 01 mid, 10 short, 11 off) |
| sel_load | input | 1 | Strobe that captures `tmo_sel` as the pending code |
| rst_drv_low | output | 1 | 1 pulls the open-drain reset line low |

## Verification
Every code is loaded and then applied with a command pulse. The bench measures the released interval and the asserted interval exactly, which separates the three periods from one another and from the reset length. A code loaded with no command end must leave the watchdog off, which shows that loading alone applies nothing. Closely spaced kicks must keep the reset released, which tells a real restart apart from a free-running counter. Supply dropouts during a running watchdog and a full power cycle check the hold behaviour, the release length and the return to the disabled default.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef enum logic [1:0] {ST_HOLD, ST_DELAY, ST_RUN} rst_state_e;
  localparam logic [1:0] SEL_OFF = 2'b11;
endpackage

// File: rtl/supv_kick_sync.sv
module supv_kick_sync (
  input  logic clk,
  input  logic pwr_on_n,
  input  logic kick_n,
  output logic kick_fall,
  output logic kick_rise
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge pwr_on_n) begin
    if (!pwr_on_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= kick_n;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign kick_fall = s3 & ~s2;
  assign kick_rise = ~s3 & s2;
endmodule

// File: rtl/supv_sel_reg.sv
module supv_sel_reg
  import supv_pkg::*;
(
  input  logic       clk,
  input  logic       pwr_on_n,
  input  logic [1:0] sel_in,
  input  logic       load,
  input  logic       apply,
  output logic [1:0] act_sel
);
  logic [1:0] pend_sel;

  always_ff @(posedge clk or negedge pwr_on_n) begin
    if (!pwr_on_n) begin
      pend_sel <= SEL_OFF;
      act_sel  <= SEL_OFF;
    end else begin
      if (load)  pend_sel <= sel_in;
      if (apply) act_sel  <= pend_sel;
    end
  end
endmodule

// File: rtl/supv_wdog.sv
module supv_wdog
  import supv_pkg::*;
#(
  parameter int unsigned WDT_LONG  = 175_000_000,
  parameter int unsigned WDT_MID   = 75_000_000,
  parameter int unsigned WDT_SHORT = 25_000_000,
  parameter int unsigned CW        = 28
) (
  input  logic          clk,
  input  logic          pwr_on_n,
  input  logic          run,
  input  logic          restart,
  input  logic [1:0]    code,
  output logic          expire,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] limit_m1;
  logic          en;

  always_comb begin
    unique case (code)
      2'b00:   limit_m1 = CW'(WDT_LONG - 1);
      2'b01:   limit_m1 = CW'(WDT_MID - 1);
      2'b10:   limit_m1 = CW'(WDT_SHORT - 1);
      default: limit_m1 = '0;
    endcase
  end

  assign en     = (code != SEL_OFF);
  assign expire = run && en && !restart && (cnt == limit_m1);

  always_ff @(posedge clk or negedge pwr_on_n) begin
    if (!pwr_on_n)                       cnt <= '0;
    else if (!run || !en || restart)     cnt <= '0;
    else if (cnt == limit_m1)            cnt <= '0;
    else                                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/supv_rst_fsm.sv
module supv_rst_fsm
  import supv_pkg::*;
#(
  parameter int unsigned RST_TICKS = 25_000_000,
  parameter int unsigned RW        = 25
) (
  input  logic          clk,
  input  logic          pwr_on_n,
  input  logic          supply_ok,
  input  logic          expire,
  output logic          run,
  output logic          drv_low,
  output logic [RW-1:0] rcnt
);
  rst_state_e st;

  always_ff @(posedge clk or negedge pwr_on_n) begin
    if (!pwr_on_n) begin
      st   <= ST_HOLD;
      rcnt <= '0;
    end else begin
      unique case (st)
        ST_HOLD: begin
          rcnt <= '0;
          if (supply_ok) st <= ST_DELAY;
        end
        ST_DELAY: begin
          if (!supply_ok) begin
            st   <= ST_HOLD;
            rcnt <= '0;
          end else if (rcnt == RW'(RST_TICKS - 1)) begin
            st   <= ST_RUN;
            rcnt <= '0;
          end else begin
            rcnt <= rcnt + 1'b1;
          end
        end
        default: begin
          if (!supply_ok) st <= ST_HOLD;
          else if (expire) begin
            st   <= ST_DELAY;
            rcnt <= '0;
          end
        end
      endcase
    end
  end

  assign run     = (st == ST_RUN);
  assign drv_low = ~run;
endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen #(
  parameter int unsigned RST_TICKS = 25_000_000,
  parameter int unsigned WDT_LONG  = 175_000_000,
  parameter int unsigned WDT_MID   = 75_000_000,
  parameter int unsigned WDT_SHORT = 25_000_000
) (
  input  logic       clk,
  input  logic       pwr_on_n,
  input  logic       supply_ok,
  input  logic       kick_n,
  input  logic [1:0] tmo_sel,
  input  logic       sel_load,
  output logic       rst_drv_low
);
  localparam int unsigned WMAX = (WDT_LONG > WDT_MID) ?
                                 ((WDT_LONG > WDT_SHORT) ? WDT_LONG : WDT_SHORT) :
                                 ((WDT_MID > WDT_SHORT) ? WDT_MID : WDT_SHORT);
  localparam int unsigned WCW = $clog2(WMAX + 1);
  localparam int unsigned RCW = $clog2(RST_TICKS + 1);

  logic           kick_fall, kick_rise;
  logic [1:0]     act_sel;
  logic           wd_expire, run;
  logic [WCW-1:0] wd_cnt;
  logic [RCW-1:0] rst_cnt;

  supv_kick_sync u_sync (
    .clk(clk), .pwr_on_n(pwr_on_n), .kick_n(kick_n),
    .kick_fall(kick_fall), .kick_rise(kick_rise)
  );

  supv_sel_reg u_sel (
    .clk(clk), .pwr_on_n(pwr_on_n), .sel_in(tmo_sel),
    .load(sel_load), .apply(kick_rise), .act_sel(act_sel)
  );

  supv_wdog #(
    .WDT_LONG(WDT_LONG), .WDT_MID(WDT_MID), .WDT_SHORT(WDT_SHORT), .CW(WCW)
  ) u_wdog (
    .clk(clk), .pwr_on_n(pwr_on_n), .run(run),
    .restart(kick_fall | kick_rise), .code(act_sel),
    .expire(wd_expire), .cnt(wd_cnt)
  );

  supv_rst_fsm #(.RST_TICKS(RST_TICKS), .RW(RCW)) u_fsm (
    .clk(clk), .pwr_on_n(pwr_on_n), .supply_ok(supply_ok),
    .expire(wd_expire), .run(run), .drv_low(rst_drv_low), .rcnt(rst_cnt)
  );
endmodule

// File: rtl/supv_reset_chk.sv
module supv_reset_chk #(
  parameter int unsigned RST_TICKS = 20,
  parameter int unsigned CW        = 8,
  parameter int unsigned RW        = 8
) (
  input logic          clk,
  input logic          pwr_on_n,
  input logic          supply_ok,
  input logic          drv_low,
  input logic          kick_rise,
  input logic [1:0]    act_sel,
  input logic          wd_expire,
  input logic [CW-1:0] wd_cnt,
  input logic [RW-1:0] rst_cnt
);
  assert_supply_hold_R2: assert property (@(posedge clk) disable iff (!pwr_on_n)
    !supply_ok |=> drv_low);

  assert_release_needs_supply_R3: assert property (@(posedge clk) disable iff (!pwr_on_n)
    $fell(drv_low) |-> $past(supply_ok));

  assert_expire_resets_R4: assert property (@(posedge clk) disable iff (!pwr_on_n)
    wd_expire |=> drv_low);

  assert_off_no_expire_R5: assert property (@(posedge clk) disable iff (!pwr_on_n)
    (act_sel == 2'b11) |-> !wd_expire);

  assert_delay_bound_R7: assert property (@(posedge clk) disable iff (!pwr_on_n)
    rst_cnt < RW'(RST_TICKS));

  assert_sel_only_at_cmd_end_R9: assert property (@(posedge clk) disable iff (!pwr_on_n)
    !kick_rise |=> $stable(act_sel));

  assert_cnt_cleared_in_reset_R10: assert property (@(posedge clk) disable iff (!pwr_on_n)
    (drv_low && $past(drv_low)) |-> (wd_cnt == '0));
endmodule

bind supv_reset_gen supv_reset_chk #(
  .RST_TICKS(RST_TICKS), .CW(WCW), .RW(RCW)
) chk_i (
  .clk(clk), .pwr_on_n(pwr_on_n), .supply_ok(supply_ok), .drv_low(rst_drv_low),
  .kick_rise(kick_rise), .act_sel(act_sel), .wd_expire(wd_expire),
  .wd_cnt(wd_cnt), .rst_cnt(rst_cnt)
);

// File: tb/supv_reset_gen_tb_top.sv
module supv_reset_gen_tb_top;
  localparam int RT    = 20;
  localparam int LONG  = 70;
  localparam int MID   = 30;
  localparam int SHORT = 10;
  localparam int CAP   = 1000;

  logic       clk = 1'b0;
  logic       pwr_on_n = 1'b0;
  logic       supply_ok = 1'b1;
  logic       kick_n = 1'b1;
  logic [1:0] tmo_sel = 2'b00;
  logic       sel_load = 1'b0;
  logic       rst_drv_low;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  supv_reset_gen #(
    .RST_TICKS(RT), .WDT_LONG(LONG), .WDT_MID(MID), .WDT_SHORT(SHORT)
  ) dut_i (
    .clk(clk), .pwr_on_n(pwr_on_n), .supply_ok(supply_ok), .kick_n(kick_n),
    .tmo_sel(tmo_sel), .sel_load(sel_load), .rst_drv_low(rst_drv_low)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // cycles (sampled 1 ns after each rising edge) until rst_drv_low equals lvl
  task automatic count_until(input logic lvl, output int n);
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
    end while (rst_drv_low !== lvl && n < CAP);
  endtask

  // checks that rst_drv_low stays 0 for cyc cycles
  task automatic stay_released(input int cyc, input string req);
    int bad = 0;
    for (int i = 0; i < cyc; i++) begin
      @(posedge clk); #1;
      if (rst_drv_low !== 1'b0) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic load_code(input logic [1:0] c);
    @(negedge clk); tmo_sel = c; sel_load = 1'b1;
    @(negedge clk); sel_load = 1'b0;
  endtask

  // low for 3 cycles, then high; returns at the negedge where kick_n rises
  task automatic kick_pulse();
    @(negedge clk); kick_n = 1'b0;
    repeat (3) @(negedge clk);
    kick_n = 1'b1;
  endtask

  initial begin
    int n;
    int lim [3];
    lim[0] = LONG; lim[1] = MID; lim[2] = SHORT;

    repeat (3) @(posedge clk);
    #1 chk(rst_drv_low === 1'b1, "R11 reset state drives low", int'(rst_drv_low), 1);

    // R1: power-on delay
    @(negedge clk); pwr_on_n = 1'b1;
    count_until(1'b0, n);
    chk(n == RT + 1, "R1 power-on hold length", n, RT + 1);

    // R5/R6: default code is off
    stay_released(4 * LONG, "R6 default code keeps watchdog off");

    // R9: loaded code without command end has no effect
    load_code(2'b10);
    stay_released(4 * LONG, "R9 pending code not applied before command end");

    // R4/R7/R10: sweep codes 10, 01, 00
    for (int k = 2; k >= 0; k--) begin
      load_code(2'(k));
      kick_pulse();
      count_until(1'b1, n);
      chk(n == 3 + lim[k], "R9 R4 period after apply", n, 3 + lim[k]);
      count_until(1'b0, n);
      chk(n == RT, "R7 watchdog reset length", n, RT);
      count_until(1'b1, n);
      chk(n == lim[k], "R10 R4 full period after reset", n, lim[k]);
      count_until(1'b0, n);
      chk(n == RT, "R7 watchdog reset length again", n, RT);
    end

    // R8: kicks every 20 cycles with a 70-cycle period: never reset
    begin
      int bad = 0;
      for (int j = 0; j < 12; j++) begin
        @(negedge clk); kick_n = 1'b0;
        repeat (2) @(negedge clk);
        kick_n = 1'b1;
        for (int i = 0; i < 17; i++) begin
          @(posedge clk); #1;
          if (rst_drv_low !== 1'b0) bad++;
        end
      end
      chk(bad == 0, "R8 periodic kicks prevent reset", bad, 0);
    end

    // R5: switch off
    load_code(2'b11);
    kick_pulse();
    stay_released(4 * LONG, "R5 code 11 disables watchdog");

    // R2/R3/R10: supply dropout with short period active
    load_code(2'b10);
    kick_pulse();
    repeat (4) @(negedge clk);
    supply_ok = 1'b0;
    @(posedge clk); #1;
    chk(rst_drv_low === 1'b1, "R2 reset one cycle after supply low", int'(rst_drv_low), 1);
    begin
      int bad = 0;
      for (int i = 0; i < 30; i++) begin
        @(posedge clk); #1;
        if (rst_drv_low !== 1'b1) bad++;
      end
      chk(bad == 0, "R2 reset held while supply low", bad, 0);
    end
    @(negedge clk); supply_ok = 1'b1;
    count_until(1'b0, n);
    chk(n == RT + 1, "R3 hold after supply returns", n, RT + 1);
    count_until(1'b1, n);
    chk(n == SHORT, "R10 full period after supply reset", n, SHORT);

    // R2 during watchdog delay
    repeat (3) @(negedge clk);
    supply_ok = 1'b0;
    repeat (2 * RT) @(negedge clk);
    #1 chk(rst_drv_low === 1'b1, "R2 supply low during watchdog delay", int'(rst_drv_low), 1);
    @(negedge clk); supply_ok = 1'b1;
    count_until(1'b0, n);
    chk(n == RT + 1, "R3 hold after dropout in delay", n, RT + 1);

    // R6: power cycle returns to off, pending too
    load_code(2'b10);
    @(negedge clk); pwr_on_n = 1'b0;
    repeat (3) @(negedge clk);
    pwr_on_n = 1'b1;
    count_until(1'b0, n);
    chk(n == RT + 1, "R1 hold after power cycle", n, RT + 1);
    stay_released(4 * LONG, "R6 off after power cycle");
    kick_pulse();
    stay_released(4 * LONG, "R6 pending code cleared by power cycle");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog timeout actual=%0d expected=%0d", 1, 0);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule